// File: doc/BRIEF.md
# Bridge Transaction Ordering Queue

This block holds the transactions waiting to cross a two-port bus bridge in one direction. It decides which of them the outbound master should attempt next. Every entry carries a class code and an opaque handle that stands for the address and data kept elsewhere. The output side offers one candidate at a time. Each attempt comes back either completed or retried. A retried entry stays where it is in the age order, and the queue then moves the offer to another entry that is allowed to go. This keeps retried delayed transactions from blocking one another.

Class codes are fixed: 0 posted write (PW), 1 delayed read request (DRR), 2 delayed write request (DWR), 3 delayed read completion (DRC), 4 delayed write completion (DWC). Codes 5 to 7 are invalid. Storage keeps entries oldest first. Completing an entry removes it from any slot and closes the gap. Delayed entries may fill only part of the queue, so the last slots stay free for posted writes.

Top module: `bridge_order_queue`

## Requirements
- R1: A posted write may pass an older DWC and no other class.
- R2: A DRR or DWR may pass an older PW, DRC or DWC, and may not pass an older DRR or DWR.
- R3: A DRC may pass only an older DRR or DWR. A DWC may pass an older DRR, DWR or PW.
- R4: An entry is eligible when it may pass every older entry in the queue. The candidate is the oldest eligible entry that is not marked as passed over. If no such entry exists, the candidate is the oldest entry. `candValid` is high exactly when the queue is non-empty.
- R5: A retry result leaves every entry in its place and marks the candidate as passed over. If no eligible entry would then be left without a mark, all marks are cleared instead. A new entry starts unmarked.
- R6: A complete result removes the candidate from whatever slot it occupies. All younger entries move one slot toward the head, keeping their relative order and their marks.
- R7: Every accepted enqueue creates its own entry. Two posted writes with the same handle are offered, and completed, as two separate transactions.
- R8: A delayed entry (codes 1 to 4) is refused while DEPTH-PW_RESERVE delayed entries (6 by default) are queued. `delayedFull` shows this condition.
- R9: A posted write is accepted whenever fewer than DEPTH entries (8) are queued, however many delayed entries there are. `postedFull` is high when DEPTH entries are queued.
- R10: After reset the queue is empty. `candValid`, `postedFull` and `delayedFull` are low.
- R11: An enqueue and a result in the same cycle both take effect. The new entry becomes the youngest one after any removal.
- R12: Enqueues with class codes 5 to 7 are refused and leave the queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Offer a new entry this cycle |
| enqClass | input | 3 | Class code of the offered entry |
| enqHandle | input | HANDLE_W | Handle of the offered entry |
| enqAccept | output | 1 | Offered entry is taken at this clock edge |
| postedFull | output | 1 | All slots are used |
| delayedFull | output | 1 | Delayed share of the slots is used |
| candValid | output | 1 | A candidate is offered |
| candClass | output | 3 | Class code of the candidate |
| candHandle | output | HANDLE_W | Handle of the candidate |
| resValid | input | 1 | Result of the attempt on the candidate |
| resDone | input | 1 | 1 completed, 0 retried |

## Verification
The hardest state to reach is a queue where several retries have marked entries and a completion then shifts the marked entries and unmarked ones together. In that state the fallback to the head and the clearing of the marks both depend on which classes sit ahead of which. The stimulus reaches it in two ways. Directed sequences put chosen class pairs in front of each other and retry the head. Long random runs retry often enough that marks pile up before completions remove entries from the middle of the queue. A reference model in the bench predicts every offered candidate.

// File: rtl/ordq_pkg.sv
package ordq_pkg;

  localparam logic [2:0] CLS_PW  = 3'd0;
  localparam logic [2:0] CLS_DRR = 3'd1;
  localparam logic [2:0] CLS_DWR = 3'd2;
  localparam logic [2:0] CLS_DRC = 3'd3;
  localparam logic [2:0] CLS_DWC = 3'd4;

  typedef struct packed {
    logic push;
    logic pop;
    logic markSkip;
    logic clearSkip;
  } ordqStrobe_t;

  // later entry of class 'later' may overtake an older entry of class 'earlier'
  function automatic logic mayPass(logic [2:0] later, logic [2:0] earlier);
    case (later)
      CLS_PW:           return earlier == CLS_DWC;
      CLS_DRR, CLS_DWR: return (earlier == CLS_PW) || (earlier == CLS_DRC) || (earlier == CLS_DWC);
      CLS_DRC:          return (earlier == CLS_DRR) || (earlier == CLS_DWR);
      CLS_DWC:          return (earlier == CLS_DRR) || (earlier == CLS_DWR) || (earlier == CLS_PW);
      default:          return 1'b0;
    endcase
  endfunction

  function automatic logic legalClass(logic [2:0] c);
    return c <= CLS_DWC;
  endfunction

endpackage

// File: rtl/ordq_store.sv
module ordq_store
  import ordq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int HANDLE_W = 16,
  parameter int IDX_W    = $clog2(DEPTH)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  ordqStrobe_t                      st,
  input  logic [IDX_W-1:0]                 popIdx,
  input  logic [IDX_W-1:0]                 skipIdx,
  input  logic [IDX_W-1:0]                 pushIdx,
  input  logic [2:0]                       pushCls,
  input  logic [HANDLE_W-1:0]              pushHdl,
  output logic [DEPTH-1:0][2:0]            clsVec,
  output logic [DEPTH-1:0][HANDLE_W-1:0]   hdlVec,
  output logic [DEPTH-1:0]                 skpVec
);

  logic [DEPTH-1:0][2:0]          upCls, nCls;
  logic [DEPTH-1:0][HANDLE_W-1:0] upHdl, nHdl;
  logic [DEPTH-1:0]               upSkp, nSkp;

  // neighbour one slot younger, feeding the compaction shift
  for (genvar g = 0; g < DEPTH; g++) begin : gUpper
    if (g < DEPTH - 1) begin : gMid
      assign upCls[g] = clsVec[g+1];
      assign upHdl[g] = hdlVec[g+1];
      assign upSkp[g] = skpVec[g+1];
    end else begin : gTop
      assign upCls[g] = '0;
      assign upHdl[g] = '0;
      assign upSkp[g] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (st.pop && (IDX_W'(i) >= popIdx)) begin
        nCls[i] = upCls[i];
        nHdl[i] = upHdl[i];
        nSkp[i] = upSkp[i];
      end else begin
        nCls[i] = clsVec[i];
        nHdl[i] = hdlVec[i];
        nSkp[i] = skpVec[i];
      end
    end
    if (st.clearSkip) begin
      nSkp = '0;
    end else if (st.markSkip) begin
      nSkp[skipIdx] = 1'b1;
    end
    if (st.push) begin
      nCls[pushIdx] = pushCls;
      nHdl[pushIdx] = pushHdl;
      nSkp[pushIdx] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clsVec <= '0;
      hdlVec <= '0;
      skpVec <= '0;
    end else begin
      clsVec <= nCls;
      hdlVec <= nHdl;
      skpVec <= nSkp;
    end
  end

  // R5: a retry without enqueue never moves or rewrites stored entries
  p_retry_keeps_entries_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((st.markSkip || st.clearSkip) && !st.push) |=> ($stable(clsVec) && $stable(hdlVec)));

  // R5: marks and removal are never requested together
  p_retry_excludes_pop_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(st.pop && (st.markSkip || st.clearSkip)));

endmodule

// File: rtl/ordq_ctrl.sv
module ordq_ctrl
  import ordq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int RESERVE = 2,
  parameter int IDX_W   = $clog2(DEPTH),
  parameter int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     enqValid,
  input  logic [2:0]               enqClass,
  input  logic                     resValid,
  input  logic                     resDone,
  input  logic [DEPTH-1:0][2:0]    clsVec,
  input  logic [DEPTH-1:0]         skpVec,
  output ordqStrobe_t              st,
  output logic [IDX_W-1:0]         candIdx,
  output logic [IDX_W-1:0]         pushIdx,
  output logic                     candValid,
  output logic                     enqAccept,
  output logic                     postedFull,
  output logic                     delayedFull
);

  localparam int DELAYED_MAX = DEPTH - RESERVE;

  logic [CNT_W-1:0] count, delayedCnt;
  logic [DEPTH-1:0] validMask, eligMask, freshMask, nextSkip;
  logic             anyLeft;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      validMask[i] = CNT_W'(i) < count;
    end
  end

  // eligibility: may overtake every older entry
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      eligMask[i] = 1'b1;
      for (int j = 0; j < DEPTH; j++) begin
        if (j < i && !mayPass(clsVec[i], clsVec[j])) eligMask[i] = 1'b0;
      end
    end
  end

  assign freshMask = eligMask & validMask & ~skpVec;

  // oldest fresh eligible entry, head as fallback
  always_comb begin
    candIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (freshMask[i]) candIdx = IDX_W'(i);
    end
  end

  assign nextSkip = skpVec | (DEPTH'(1) << candIdx);
  assign anyLeft  = |(eligMask & validMask & ~nextSkip);

  always_comb begin
    delayedCnt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (validMask[i] && clsVec[i] != CLS_PW) delayedCnt = delayedCnt + CNT_W'(1);
    end
  end

  assign candValid   = count != '0;
  assign postedFull  = count == CNT_W'(DEPTH);
  assign delayedFull = delayedCnt >= CNT_W'(DELAYED_MAX);
  assign enqAccept   = enqValid && legalClass(enqClass) &&
                       ((enqClass == CLS_PW) ? !postedFull : (!delayedFull && !postedFull));

  always_comb begin
    st.push      = enqAccept;
    st.pop       = resValid && resDone && candValid;
    st.markSkip  = resValid && !resDone && candValid && anyLeft;
    st.clearSkip = resValid && !resDone && candValid && !anyLeft;
  end

  assign pushIdx = st.pop ? IDX_W'(count - CNT_W'(1)) : IDX_W'(count);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      case ({st.push, st.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the slot count
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8: delayed entries never take the posted-write reserve
  p_delayed_cap_r8: assert property (@(posedge clk) disable iff (!rstN)
    delayedCnt <= CNT_W'(DELAYED_MAX));

  // R7: an accepted enqueue always adds a distinct entry
  p_push_grows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.push && !st.pop) |=> (count == $past(count) + CNT_W'(1)));

  // R6: a completion removes exactly one entry
  p_pop_shrinks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.pop && !st.push) |=> (count == $past(count) - CNT_W'(1)));

  // R4: the candidate may overtake every older queued entry, unless it is the head
  for (genvar j = 0; j < DEPTH; j++) begin : gPassChk
    p_cand_passes_r4: assert property (@(posedge clk) disable iff (!rstN)
      (candValid && (IDX_W'(j) < candIdx)) |-> mayPass(clsVec[candIdx], clsVec[j]));
  end

endmodule

// File: rtl/bridge_order_queue.sv
module bridge_order_queue
  import ordq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int PW_RESERVE = 2,
  parameter int HANDLE_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enqValid,
  input  logic [2:0]          enqClass,
  input  logic [HANDLE_W-1:0] enqHandle,
  output logic                enqAccept,
  output logic                postedFull,
  output logic                delayedFull,
  output logic                candValid,
  output logic [2:0]          candClass,
  output logic [HANDLE_W-1:0] candHandle,
  input  logic                resValid,
  input  logic                resDone
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  ordqStrobe_t                    st;
  logic [IDX_W-1:0]               candIdx, pushIdx;
  logic [DEPTH-1:0][2:0]          clsVec;
  logic [DEPTH-1:0][HANDLE_W-1:0] hdlVec;
  logic [DEPTH-1:0]               skpVec;

  ordq_ctrl #(
    .DEPTH(DEPTH), .RESERVE(PW_RESERVE), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .enqValid(enqValid), .enqClass(enqClass),
    .resValid(resValid), .resDone(resDone),
    .clsVec(clsVec), .skpVec(skpVec),
    .st(st), .candIdx(candIdx), .pushIdx(pushIdx),
    .candValid(candValid), .enqAccept(enqAccept),
    .postedFull(postedFull), .delayedFull(delayedFull)
  );

  ordq_store #(
    .DEPTH(DEPTH), .HANDLE_W(HANDLE_W), .IDX_W(IDX_W)
  ) uStore (
    .clk(clk), .rstN(rstN), .st(st),
    .popIdx(candIdx), .skipIdx(candIdx), .pushIdx(pushIdx),
    .pushCls(enqClass), .pushHdl(enqHandle),
    .clsVec(clsVec), .hdlVec(hdlVec), .skpVec(skpVec)
  );

  assign candClass  = clsVec[candIdx];
  assign candHandle = hdlVec[candIdx];

endmodule

// File: tb/tb_bridge_order_queue.sv
`timescale 1ns/100ps
module tb_bridge_order_queue;

  localparam int DEPTH = 8;
  localparam int RSV   = 2;
  localparam int HW    = 16;
  localparam int SAMEH = 16'h0055;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0;
  logic [2:0] enqClass = '0;
  logic [HW-1:0] enqHandle = '0;
  logic enqAccept, postedFull, delayedFull, candValid;
  logic [2:0] candClass;
  logic [HW-1:0] candHandle;
  logic resValid = 1'b0, resDone = 1'b0;

  always #2.5 clk = ~clk;

  bridge_order_queue #(.DEPTH(DEPTH), .PW_RESERVE(RSV), .HANDLE_W(HW)) dut (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqClass(enqClass),
    .enqHandle(enqHandle), .enqAccept(enqAccept), .postedFull(postedFull),
    .delayedFull(delayedFull), .candValid(candValid), .candClass(candClass),
    .candHandle(candHandle), .resValid(resValid), .resDone(resDone)
  );

  typedef struct { int cls; int hdl; bit skp; } ent_t;
  typedef struct { bit cv; int cc; int ch; bit acc; bit pf; bit df; string tag; } exp_t;

  ent_t mq[$];
  exp_t expQ[$];
  int checks = 0, errors = 0;
  int sameEnq = 0, sameDone = 0;

  function automatic bit canPass(int l, int e);
    case (l)
      0: return e == 4;
      1, 2: return e == 0 || e == 3 || e == 4;
      3: return e == 1 || e == 2;
      4: return e == 0 || e == 1 || e == 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit eligAt(int i);
    for (int j = 0; j < i; j++) if (!canPass(mq[i].cls, mq[j].cls)) return 0;
    return 1;
  endfunction

  function automatic int pickIdx();
    for (int i = 0; i < mq.size(); i++) if (eligAt(i) && !mq[i].skp) return i;
    return 0;
  endfunction

  function automatic int delayedCount();
    int n = 0;
    foreach (mq[i]) if (mq[i].cls != 0) n++;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus, queues expected outputs, updates the model
  task automatic step(input bit ev, input int ec, input int eh, input bit rv, input bit rd, input string tag);
    exp_t e;
    int idx, n;
    @(negedge clk);
    enqValid = ev; enqClass = ec[2:0]; enqHandle = eh[HW-1:0];
    resValid = rv; resDone = rd;
    n = mq.size();
    idx = pickIdx();
    e.cv = n > 0;
    e.cc = (n > 0) ? mq[idx].cls : 0;
    e.ch = (n > 0) ? mq[idx].hdl : 0;
    e.pf = n >= DEPTH;
    e.df = delayedCount() >= DEPTH - RSV;
    e.acc = ev && ec < 5 && ((ec == 0) ? !e.pf : (!e.df && !e.pf));
    e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    if (rv && n > 0) begin
      if (rd) mq.delete(idx);
      else begin
        bit left = 0;
        mq[idx].skp = 1;
        for (int i = 0; i < mq.size(); i++) if (eligAt(i) && !mq[i].skp) left = 1;
        if (!left) foreach (mq[i]) mq[i].skp = 0;
      end
    end
    if (e.acc) begin
      ent_t ne;
      ne.cls = ec; ne.hdl = eh; ne.skp = 0;
      mq.push_back(ne);
      if (ec == 0 && eh == SAMEH) sameEnq++;
    end
  endtask

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(candValid == e.cv, e.tag, "candValid", candValid, e.cv);
      if (e.cv) begin
        chk(candClass == e.cc[2:0], e.tag, "candClass", candClass, e.cc);
        chk(candHandle == e.ch[HW-1:0], e.tag, "candHandle", candHandle, e.ch);
        if (resValid && resDone && candClass == 3'd0 && candHandle == SAMEH[HW-1:0]) sameDone++;
      end
      chk(enqAccept == e.acc, e.tag, "enqAccept", enqAccept, e.acc);
      chk(postedFull == e.pf, e.tag, "postedFull", postedFull, e.pf);
      chk(delayedFull == e.df, e.tag, "delayedFull", delayedFull, e.df);
    end
  end

  task automatic drain(input string tag);
    while (mq.size() > 0) step(0, 0, 0, 1, 1, tag);
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    step(0, 0, 0, 0, 0, "R10");                 // empty after reset
    // R1: PW overtakes a retried DWC
    step(1, 4, 1, 0, 0, "R1"); step(1, 0, 2, 0, 0, "R1");
    step(0, 0, 0, 1, 0, "R1"); step(0, 0, 0, 0, 0, "R1");
    drain("R1");
    // R1/R5: PW may not pass DRC; marks clear and the head returns
    step(1, 3, 3, 0, 0, "R5"); step(1, 0, 4, 0, 0, "R5");
    step(0, 0, 0, 1, 0, "R5"); step(0, 0, 0, 0, 0, "R5");
    drain("R5");
    // R3: DWC passes PW, DRC does not
    step(1, 0, 5, 0, 0, "R3"); step(1, 4, 6, 0, 0, "R3");
    step(0, 0, 0, 1, 0, "R3"); step(0, 0, 0, 0, 0, "R3");
    drain("R3");
    step(1, 0, 7, 0, 0, "R3"); step(1, 3, 8, 0, 0, "R3");
    step(0, 0, 0, 1, 0, "R3"); step(0, 0, 0, 0, 0, "R3");
    drain("R3");
    // R2: request passes a completion, not another request
    step(1, 3, 9, 0, 0, "R2"); step(1, 1, 10, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R2"); step(0, 0, 0, 0, 0, "R2");
    drain("R2");
    step(1, 1, 11, 0, 0, "R2"); step(1, 2, 12, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R2"); step(0, 0, 0, 0, 0, "R2");
    drain("R2");
    // R6: complete a non-head entry, younger ones close the gap
    step(1, 3, 13, 0, 0, "R6"); step(1, 1, 14, 0, 0, "R6"); step(1, 0, 15, 0, 0, "R6");
    step(0, 0, 0, 1, 0, "R6"); step(0, 0, 0, 1, 1, "R6"); step(0, 0, 0, 0, 0, "R6");
    drain("R6");
    // R8/R9: delayed share fills, posted writes still enter, then all full
    for (int k = 0; k < 7; k++) step(1, 1 + (k % 4), 20 + k, 0, 0, "R8");
    step(1, 0, 30, 0, 0, "R9"); step(1, 0, 31, 0, 0, "R9");
    step(1, 0, 32, 0, 0, "R9"); step(1, 2, 33, 0, 0, "R9");
    // R11: enqueue and completion in one cycle while full
    step(1, 0, 34, 1, 1, "R11"); step(1, 0, 35, 1, 1, "R11");
    drain("R11");
    // R12: illegal class codes refused
    step(1, 5, 40, 0, 0, "R12"); step(1, 7, 41, 0, 0, "R12"); step(0, 0, 0, 0, 0, "R12");
    // R7: same-handle posted writes stay separate
    step(1, 0, SAMEH, 0, 0, "R7"); step(1, 0, SAMEH, 0, 0, "R7");
    step(0, 0, 0, 0, 0, "R7");
    drain("R7");
    // random traffic for R4/R5/R6/R7
    for (int k = 0; k < 4000; k++) begin
      int c, h;
      c = $urandom_range(0, 5);
      h = ($urandom_range(0, 3) == 0) ? SAMEH : $urandom_range(0, 999);
      step($urandom_range(0, 9) < 6, c, h, $urandom_range(0, 9) < 5,
           $urandom_range(0, 2) == 0, "R4");
    end
    drain("R4");
    step(0, 0, 0, 0, 0, "R4");
    chk(sameDone == sameEnq, "R7", "same-handle PW completions", sameDone, sameEnq);
    finishRun();
  end

endmodule